// File: doc/BRIEF.md
# Conversion-Result Queue with Threshold Requests

This block buffers the output of a sampling converter until a bus master or a DMA engine collects it. Each time the converter signals a finished conversion, and capture is switched on, the result is reformatted and appended to a short first-in first-out queue. The result can be stored at full width or narrowed to its top eight bits. It can also carry the conversion's error flag in the top bit of the stored word. A consumer reads the oldest entry on `pop_data` and removes it with a one-cycle `pop` strobe.

A single 32-bit control/status word is written through `reg_wr`/`reg_wdata` and can be read at any time on `reg_rdata`. Through it, software enables capture, picks the format, gates the DMA request and sets a 4-bit occupancy threshold. The same word shows empty and full status and the current occupancy. It also holds two sticky error flags: underflow, for a pop from an empty queue, and overflow, for a push into a full queue. Writing 1 to a flag clears it. The interrupt is asserted whenever the occupancy is at or above the threshold. The DMA request follows the same condition but is also gated by its enable bit.

Top module: `conv_result_fifo`

## Requirements
- R1: After reset, every writable field is 0, the queue is empty, `reg_rdata` reads 32'h0000_0100 (only the empty bit, bit 8, set) and `pop_data` is 0.
- R2: With the capture enable (bit 0) at 0, `conv_valid` pulses change nothing: the level stays 0 and no flag is set.
- R3: With bit 0 at 1, each `conv_valid` pulse appends one entry, and entries leave in arrival order. In full-width mode an entry holds the result in bits 11:0, with all other bits 0. `pop_data` shows the oldest entry combinationally, and a `pop` removes it at the clock edge.
- R4: With byte mode (bit 1) at 1 when a sample is pushed, the entry holds result[11:4] in bits 7:0, and bits 14:8 are 0.
- R5: With the error-tag option (bit 2) at 1 when a sample is pushed, bit 15 of the entry equals `conv_err`. With the option at 0, bit 15 is 0.
- R6: `reg_rdata[19:16]` gives the number of held entries (0 to 4). Bit 8 is 1 exactly when that number is 0, and bit 9 is 1 exactly when it is 4.
- R7: A push into a full queue without a pop in the same cycle drops the sample, leaves the contents unchanged and sets the overflow flag (bit 11).
- R8: A pop from an empty queue leaves the level at 0 and sets the underflow flag (bit 10). While the queue is empty, `pop_data` is 0.
- R9: Writing 1 to bit 10 or bit 11 clears that flag, and writing 0 leaves it unchanged. If a new underflow or overflow event happens in the same cycle as the clear, the flag stays set.
- R10: A push and a pop in the same cycle on a non-empty queue leave the level unchanged. This holds even when the queue is full, and in that case no overflow is flagged. On an empty queue, the pop counts as an underflow and the push is still stored.
- R11: With the threshold in bits 27:24, `irq` is 1 exactly when level >= threshold. `dma_req` is 1 exactly when that holds and the DMA enable (bit 3) is 1.
- R12: Bits 7:4, 15:12, 23:20 and 31:28 of `reg_rdata` always read 0, and writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_valid | input | 1 | One-cycle pulse: a conversion finished |
| conv_result | input | 12 | Conversion result (RES_W) |
| conv_err | input | 1 | Error flag of this conversion |
| reg_wr | input | 1 | Write strobe for the control/status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Control/status word read value |
| pop | input | 1 | Remove the oldest entry |
| pop_data | output | 16 | Oldest entry, or 0 when empty (ENTRY_W) |
| dma_req | output | 1 | DMA request: level at or above threshold, gated by bit 3 |
| irq | output | 1 | Interrupt: level at or above threshold |

## Verification
The bench uses the default parameters: a 12-bit result, a 16-bit entry and a depth of 4. The 4-bit threshold can therefore take values above the depth (5 to 15), which must never fire, as well as 0, which always fires. With a depth of 4, the full condition, overflow and push-with-pop on a full queue are all reached within a few cycles. The pointer wrap is taken many times during the random phase. With a 12-bit result, byte mode actually shifts the data, since four low bits are discarded.

// File: rtl/crf_pkg.sv
package crf_pkg;
   localparam int REG_W   = 32;
   localparam int LVL_W   = 4;
   localparam int B_EN    = 0;
   localparam int B_BYTE  = 1;
   localparam int B_ETAG  = 2;
   localparam int B_DMA   = 3;
   localparam int B_EMPTY = 8;
   localparam int B_FULL  = 9;
   localparam int B_UNDER = 10;
   localparam int B_OVER  = 11;
   localparam int B_LVL   = 16;
   localparam int B_THR   = 24;

   typedef struct packed {
      logic [LVL_W-1:0] thresh;
      logic             dma_en;
      logic             err_tag;
      logic             byte_mode;
      logic             en;
   } crf_ctrl_t;
endpackage

// File: rtl/crf_format.sv
module crf_format #(
   parameter int RES_W   = 12,
   parameter int ENTRY_W = 16
) (
   input  logic [RES_W-1:0]   result,
   input  logic               err,
   input  logic               byte_mode,
   input  logic               err_tag,
   output logic [ENTRY_W-1:0] entry
);
   localparam int ERR_POS = ENTRY_W - 1;

   logic [7:0] narrow;

   generate
      if (RES_W == 8) begin : g_same
         assign narrow = result;
      end else begin : g_shift
         assign narrow = result[RES_W-1 -: 8];
      end
   endgenerate

   always_comb begin
      entry = '0;
      if (byte_mode) entry[7:0] = narrow;
      else           entry[RES_W-1:0] = result;
      if (err_tag)   entry[ERR_POS] = err;
   end
endmodule

// File: rtl/crf_store.sv
module crf_store #(
   parameter int DEPTH   = 4,
   parameter int ENTRY_W = 16,
   parameter int LVL_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic [ENTRY_W-1:0] din,
   input  logic               pop,
   output logic [ENTRY_W-1:0] head,
   output logic [LVL_W-1:0]   level,
   output logic               empty,
   output logic               full,
   output logic               over_evt,
   output logic               under_evt
);
   localparam int PW = $clog2(DEPTH);
   localparam logic [PW-1:0]    LAST = PW'(DEPTH - 1);
   localparam logic [LVL_W-1:0] CAP  = LVL_W'(DEPTH);

   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [PW-1:0] wptr, rptr, wnext, rnext;
   logic wr_en, rd_en;

   assign empty     = (level == '0);
   assign full      = (level == CAP);
   assign rd_en     = pop && !empty;
   assign wr_en     = push && (!full || pop);
   assign over_evt  = push && full && !pop;
   assign under_evt = pop && empty;
   assign head      = empty ? '0 : mem[rptr];

   generate
      if ((1 << PW) == DEPTH) begin : g_pow2
         assign wnext = wptr + 1'b1;
         assign rnext = rptr + 1'b1;
      end else begin : g_wrap
         assign wnext = (wptr == LAST) ? '0 : wptr + 1'b1;
         assign rnext = (rptr == LAST) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) mem[wptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (wr_en) wptr <= wnext;
         if (rd_en) rptr <= rnext;
         case ({wr_en, rd_en})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CAP);
   p_drop_keeps_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      over_evt |=> level == $past(level));
   p_underflow_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      under_evt && !push |=> level == '0);
   p_pushpop_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
      push && pop && !empty |=> level == $past(level));
endmodule

// File: rtl/crf_csr.sv
module crf_csr
   import crf_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             set_under,
   input  logic             set_over,
   input  logic [LVL_W-1:0] level,
   input  logic             empty,
   input  logic             full,
   output crf_ctrl_t        ctrl,
   output logic [REG_W-1:0] rdata
);
   logic under, over;
   logic unused_wbits;

   assign unused_wbits = ^{wdata[31:28], wdata[23:12], wdata[9:4]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl  <= '0;
         under <= 1'b0;
         over  <= 1'b0;
      end else begin
         if (wr) begin
            ctrl.en        <= wdata[B_EN];
            ctrl.byte_mode <= wdata[B_BYTE];
            ctrl.err_tag   <= wdata[B_ETAG];
            ctrl.dma_en    <= wdata[B_DMA];
            ctrl.thresh    <= wdata[B_THR +: LVL_W];
         end
         if (set_under)                 under <= 1'b1;
         else if (wr && wdata[B_UNDER]) under <= 1'b0;
         if (set_over)                  over  <= 1'b1;
         else if (wr && wdata[B_OVER])  over  <= 1'b0;
      end
   end

   always_comb begin
      rdata                 = '0;
      rdata[B_EN]           = ctrl.en;
      rdata[B_BYTE]         = ctrl.byte_mode;
      rdata[B_ETAG]         = ctrl.err_tag;
      rdata[B_DMA]          = ctrl.dma_en;
      rdata[B_EMPTY]        = empty;
      rdata[B_FULL]         = full;
      rdata[B_UNDER]        = under;
      rdata[B_OVER]         = over;
      rdata[B_LVL +: LVL_W] = level;
      rdata[B_THR +: LVL_W] = ctrl.thresh;
   end

   p_w1c_under_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr && wdata[B_UNDER] && !set_under |=> !under);
   p_sticky_over_r9: assert property (@(posedge clk) disable iff (!rst_n)
      over && !(wr && wdata[B_OVER]) |=> over);
   p_under_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_under |=> under);
   p_over_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set_over |=> over);
endmodule

// File: rtl/conv_result_fifo.sv
module conv_result_fifo
   import crf_pkg::*;
#(
   parameter int DEPTH   = 4,
   parameter int RES_W   = 12,
   parameter int ENTRY_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               conv_valid,
   input  logic [RES_W-1:0]   conv_result,
   input  logic               conv_err,
   input  logic               reg_wr,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   input  logic               pop,
   output logic [ENTRY_W-1:0] pop_data,
   output logic               dma_req,
   output logic               irq
);
   generate
      if (DEPTH < 2 || DEPTH >= (1 << LVL_W)) begin : g_bad_depth
         $error("DEPTH must lie in 2..%0d", (1 << LVL_W) - 1);
      end
      if (RES_W < 8 || RES_W >= ENTRY_W) begin : g_bad_res
         $error("RES_W must be at least 8 and below ENTRY_W");
      end
   endgenerate

   crf_ctrl_t          ctrl;
   logic [ENTRY_W-1:0] entry;
   logic [LVL_W-1:0]   level;
   logic               empty, full, over_evt, under_evt, hit;

   crf_format #(.RES_W(RES_W), .ENTRY_W(ENTRY_W)) u_fmt (
      .result(conv_result), .err(conv_err), .byte_mode(ctrl.byte_mode),
      .err_tag(ctrl.err_tag), .entry(entry));

   crf_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .LVL_W(LVL_W)) u_store (
      .clk(clk), .rst_n(rst_n), .push(conv_valid && ctrl.en), .din(entry),
      .pop(pop), .head(pop_data), .level(level), .empty(empty), .full(full),
      .over_evt(over_evt), .under_evt(under_evt));

   crf_csr u_csr (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
      .set_under(under_evt), .set_over(over_evt), .level(level),
      .empty(empty), .full(full), .ctrl(ctrl), .rdata(reg_rdata));

   assign hit     = (level >= ctrl.thresh);
   assign irq     = hit;
   assign dma_req = hit && ctrl.dma_en;

   p_dma_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[B_DMA] |-> !dma_req);
   p_empty_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[B_EMPTY] |-> pop_data == '0);
   p_disabled_no_growth_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[B_EN] && !reg_wr |=> reg_rdata[B_LVL +: LVL_W] <= $past(reg_rdata[B_LVL +: LVL_W]));
   p_reserved_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      {reg_rdata[31:28], reg_rdata[23:20], reg_rdata[15:12], reg_rdata[7:4]} == '0);
endmodule

// File: tb/sim_conv_result_fifo.sv
module sim_conv_result_fifo;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_valid = 1'b0;
   logic [11:0] conv_result = '0;
   logic        conv_err = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        pop = 1'b0;
   logic [31:0] reg_rdata;
   logic [15:0] pop_data;
   logic        dma_req, irq;

   int checks = 0, errs = 0;
   bit done = 0;
   string cur_tag = "R1";

   bit m_en, m_byte, m_etag, m_dma, m_und, m_ovr;
   logic [3:0] m_thr;
   logic [15:0] q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   conv_result_fifo u0 (
      .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_result(conv_result),
      .conv_err(conv_err), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pop(pop), .pop_data(pop_data), .dma_req(dma_req), .irq(irq));

   task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   task automatic model_update();
      bit push, was_empty, was_full;
      logic [15:0] e;
      if (!rst_n) begin
         {m_en, m_byte, m_etag, m_dma, m_und, m_ovr} = '0;
         m_thr = '0;
         q.delete();
         return;
      end
      push = conv_valid && m_en;
      was_empty = (q.size() == 0);
      was_full = (q.size() == DEPTH);
      e = '0;
      if (m_byte) e[7:0] = conv_result >> 4;
      else e[11:0] = conv_result;
      if (m_etag) e[15] = conv_err;
      if (reg_wr && reg_wdata[10]) m_und = 0;
      if (reg_wr && reg_wdata[11]) m_ovr = 0;
      if (pop && was_empty) m_und = 1;
      if (push && was_full && !pop) m_ovr = 1;
      if (pop && !was_empty) void'(q.pop_front());
      if (push && (!was_full || pop)) q.push_back(e);
      if (reg_wr) begin
         {m_dma, m_etag, m_byte, m_en} = reg_wdata[3:0];
         m_thr = reg_wdata[27:24];
      end
   endtask

   task automatic compare_all();
      logic [31:0] er;
      int n = q.size();
      bit hit = (n >= int'(m_thr));
      er = '0;
      er[3:0] = {m_dma, m_etag, m_byte, m_en};
      er[8] = (n == 0);
      er[9] = (n == DEPTH);
      er[10] = m_und;
      er[11] = m_ovr;
      er[19:16] = 4'(n);
      er[27:24] = m_thr;
      cmp({cur_tag, " reg_rdata"}, reg_rdata, er);
      cmp({cur_tag, " pop_data"}, {16'h0, pop_data}, n != 0 ? {16'h0, q[0]} : 32'h0);
      cmp({cur_tag, " irq"}, {31'h0, irq}, {31'h0, hit});
      cmp({cur_tag, " dma_req"}, {31'h0, dma_req}, {31'h0, hit && m_dma});
   endtask

   task automatic step();
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare_all();
   endtask

   task automatic cyc(bit cv, logic [11:0] res, bit ce, bit p, bit w, logic [31:0] wd);
      conv_valid = cv; conv_result = res; conv_err = ce;
      pop = p; reg_wr = w; reg_wdata = wd;
      step();
      conv_valid = 0; pop = 0; reg_wr = 0;
   endtask

   function automatic logic [31:0] cw(bit en, bit byt, bit et, bit dma, logic [3:0] thr);
      return {4'h0, thr, 20'h0, dma, et, byt, en};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
         $finish;
      end
   end

   initial begin
      logic [31:0] c;
      cur_tag = "R1";
      repeat (3) step();
      rst_n = 1;
      @(negedge clk);
      cmp("R1 reset word", reg_rdata, 32'h0000_0100);
      cmp("R1 reset data", {16'h0, pop_data}, 32'h0);

      cur_tag = "R2";
      for (int i = 0; i < 3; i++) cyc(1, 12'hA5A + 12'(i), 0, 0, 0, 0);
      cmp("R2 level after discarded samples", {28'h0, reg_rdata[19:16]}, 32'h0);

      cur_tag = "R3";
      c = cw(1, 0, 0, 1, 4'd3);
      cyc(0, 0, 0, 0, 1, c);
      for (int i = 0; i < 3; i++) cyc(1, 12'h100 * 12'(i + 1) + 12'h0F3, 0, 0, 0, 0);
      cur_tag = "R11";
      cmp("R11 dma at threshold", {31'h0, dma_req}, 32'h1);
      cur_tag = "R3";
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, 0);

      cur_tag = "R7";
      for (int i = 0; i < 6; i++) cyc(1, 12'h300 + 12'(i), 0, 0, 0, 0);
      cmp("R7 overflow flag", {31'h0, reg_rdata[11]}, 32'h1);
      cur_tag = "R6";
      cmp("R6 full bit", {31'h0, reg_rdata[9]}, 32'h1);

      cur_tag = "R10";
      cyc(1, 12'h777, 0, 1, 0, 0);
      cyc(1, 12'h778, 1, 1, 0, 0);
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 0, 0);
      cur_tag = "R8";
      cyc(0, 0, 0, 1, 0, 0);
      cmp("R8 underflow flag", {31'h0, reg_rdata[10]}, 32'h1);
      cur_tag = "R10";
      cyc(1, 12'h0AB, 0, 1, 0, 0);
      cyc(0, 0, 0, 1, 0, 0);

      cur_tag = "R9";
      cyc(0, 0, 0, 0, 1, c);
      cmp("R9 zero write keeps flags", {30'h0, reg_rdata[11:10]}, 32'h3);
      cyc(0, 0, 0, 1, 1, c | 32'h0000_0C00);
      cmp("R9 set beats clear", {30'h0, reg_rdata[11:10]}, 32'h1);
      cyc(0, 0, 0, 0, 1, c | 32'h0000_0400);
      cmp("R9 clear", {30'h0, reg_rdata[11:10]}, 32'h0);

      cur_tag = "R4";
      cyc(0, 0, 0, 0, 1, cw(1, 1, 0, 1, 4'd1));
      cyc(1, 12'hABC, 1, 0, 0, 0);
      cmp("R4 byte entry", {16'h0, pop_data}, 32'h0000_00AB);
      cyc(0, 0, 0, 1, 0, 0);

      cur_tag = "R5";
      cyc(0, 0, 0, 0, 1, cw(1, 0, 1, 1, 4'd2));
      cyc(1, 12'h123, 1, 0, 0, 0);
      cyc(1, 12'h456, 0, 0, 0, 0);
      cmp("R5 error tag", {16'h0, pop_data}, 32'h0000_8123);
      cyc(0, 0, 0, 0, 1, cw(1, 1, 1, 0, 4'd2));
      cyc(1, 12'hFFF, 1, 1, 0, 0);
      cyc(0, 0, 0, 0, 1, cw(1, 0, 0, 0, 4'd2));
      cyc(1, 12'h9EF, 1, 1, 0, 0);
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, 0);

      cur_tag = "R11";
      for (int t = 0; t < 16; t++) begin
         cyc(0, 0, 0, 0, 1, cw(1, 0, 0, t[0], 4'(t)));
         for (int k = 0; k < 5; k++) cyc(1, 12'(k), 0, 0, 0, 0);
         for (int k = 0; k < 5; k++) cyc(0, 0, 0, 1, 0, 0);
      end

      cur_tag = "R12";
      cyc(0, 0, 0, 0, 1, 32'hFFFF_FFFF);
      cmp("R12 reserved bits", reg_rdata & 32'hF0F0_F0F0, 32'h0);

      cur_tag = "R6";
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r = $urandom;
         cyc(r[0] | r[1], 12'($urandom), r[2], r[3] & r[4], r[10:5] == 0, $urandom);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
   end
endmodule